// File: doc/BRIEF.md
# Interrupt Request Gatherer with Atomic Snapshot

This block collects a set of interrupt request lines into one wide status word and signals a host through a single active-low alert pin. The lines fall into two groups. The fixed-function lines fill the lowest byte or bytes of the word. The user-logic lines follow directly above them. Whenever any synchronised line goes from 0 to 1, the alert is driven low.

The host services the alert by reading the word one byte at a time through a small read port, which takes an address and a strobe and returns a data byte. A read of byte 0 opens a readout. In that same clock cycle the alert is released and the synchronised value of every line is latched into a snapshot. The remaining bytes of the readout come from that snapshot, so the host sees one consistent picture of all lines. A new rising edge during the readout is held back until the last byte has been read, and then it raises the alert again. No event is lost to a race between the readout and a new request.

Top module: `irq_gather`

## Requirements
- R1: A 0-to-1 transition on any request line drives alert_n_o low. The line passes through two synchroniser flops, so with the input changed before clock edge k, alert_n_o is low after edge k+2.
- R2: A read strobe with address 0 releases the alert, and alert_n_o is high after that clock edge. The only exception is a rising edge detected in that same cycle.
- R3: A read of address 0 latches every synchronised line into the snapshot. The byte returned is bits 7:0 of the value that was latched.
- R4: Reads of addresses 1 to NB-1 return snapshot bytes, never the live lines.
- R5: From a byte-0 read until a read of the last address NB-1, alert_n_o stays high. A rising edge seen in that window drives alert_n_o low after the last-byte read.
- R6: Fixed-function line i sits at word bit i. User line j sits at bit 8*FIX_BYTES+j. Address a returns word bits 8a+7:8a, and an address of NB or more returns 0x00.
- R7: Falling transitions and lines that stay high do not assert the alert.
- R8: Once low, alert_n_o stays low until a read strobe occurs.
- R9: After reset, alert_n_o is high and the snapshot is all zeros.
- R10: Read data appears on rd_data_o one cycle after the strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_req_i | input | 8*FIX_BYTES | Fixed-function request lines |
| usr_req_i | input | USR_LINES | User-logic request lines |
| rd_stb_i | input | 1 | Byte read strobe |
| rd_addr_i | input | AW | Byte address within the word |
| rd_data_o | output | 8 | Registered read data |
| alert_n_o | output | 1 | Active-low alert to the host |

## Verification
Suppose the pending flag is wrong. Then alert_n_o departs from the reference within one clock of the faulty edge or read, and that is visible at the next sample. Suppose instead the snapshot or the readout window is corrupted. That shows on the first later read of a byte above 0, or on the alert level after the last-byte read. The bench moves the live lines between the capture and those reads, so a snapshot that tracks the lines is exposed at once.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] sync_o,
  output logic         edge_any_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = req_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o     = s2_q;
  assign edge_any_o = |(s2_q & ~prev_q);
endmodule

// File: rtl/irq_alert_track.sv
module irq_alert_track #(
  parameter bit MULTI = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_any_i,
  input  logic cap_i,
  input  logic done_i,
  output logic busy_o,
  output logic alert_n_o
);
  logic pend_q, pend_d;
  logic busy_q, busy_d;

  always_comb begin
    pend_d = edge_any_i | (pend_q & ~cap_i);
    if (cap_i)       busy_d = MULTI;
    else if (done_i) busy_d = 1'b0;
    else             busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o    = busy_q;
  assign alert_n_o = ~(pend_q & ~busy_q);
endmodule

// File: rtl/irq_snap_reg.sv
module irq_snap_reg #(
  parameter int W  = 32,
  parameter int NB = 4,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    live_i,
  input  logic            cap_i,
  input  logic            rd_stb_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [NB*8-1:0] snap_o,
  output logic [7:0]      rd_data_o
);
  localparam int PADW = NB * 8;

  logic [PADW-1:0] live_pad, src, snap_q, snap_d;
  logic [7:0]      data_q, data_d;
  logic            snap_en;

  always_comb begin
    live_pad         = '0;
    live_pad[W-1:0]  = live_i;
    snap_en          = cap_i;
    snap_d           = live_pad;
    src              = cap_i ? live_pad : snap_q;
    data_d           = 8'h00;
    for (int b = 0; b < NB; b++) begin
      if (rd_addr_i == AW'(b)) data_d = src[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      data_q <= '0;
    end else begin
      if (snap_en)  snap_q <= snap_d;
      if (rd_stb_i) data_q <= data_d;
    end
  end

  assign snap_o    = snap_q;
  assign rd_data_o = data_q;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int FIX_BYTES = 1,
  parameter int USR_LINES = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [FIX_BYTES*BYTE_W-1:0]   fix_req_i,
  input  logic [USR_LINES-1:0]          usr_req_i,
  input  logic                          rd_stb_i,
  input  logic [$clog2(irq_gather_pkg::bytes_for(FIX_BYTES*8+USR_LINES)+1)-1:0] rd_addr_i,
  output logic [7:0]                    rd_data_o,
  output logic                          alert_n_o
);
  localparam int FIX_W = FIX_BYTES * BYTE_W;
  localparam int TOT   = FIX_W + USR_LINES;
  localparam int NB    = bytes_for(TOT);
  localparam int AW    = $clog2(NB + 1);
  localparam int PADW  = NB * BYTE_W;

  logic [TOT-1:0]  req_all, sync_q;
  logic [PADW-1:0] snap_q;
  logic            edge_any, busy_q, cap, done;

  assign req_all = {usr_req_i, fix_req_i};
  assign cap     = rd_stb_i && (rd_addr_i == '0);
  assign done    = rd_stb_i && (rd_addr_i == AW'(NB - 1));

  irq_req_sync #(.W(TOT)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_all),
    .sync_o     (sync_q),
    .edge_any_o (edge_any)
  );

  irq_alert_track #(.MULTI(NB > 1)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_any_i (edge_any),
    .cap_i      (cap),
    .done_i     (done),
    .busy_o     (busy_q),
    .alert_n_o  (alert_n_o)
  );

  irq_snap_reg #(.W(TOT), .NB(NB), .AW(AW)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (sync_q),
    .cap_i     (cap),
    .rd_stb_i  (rd_stb_i),
    .rd_addr_i (rd_addr_i),
    .snap_o    (snap_q),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NB   = 4,
  parameter int AW   = 3,
  parameter int PADW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_stb,
  input logic [AW-1:0]   rd_addr,
  input logic [7:0]      rd_data,
  input logic            alert_n,
  input logic            edge_any,
  input logic            busy,
  input logic [PADW-1:0] snap,
  input logic [7:0]      live_lo
);
  p_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_any && !rd_stb && !busy |=> !alert_n);

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == '0 && !edge_any |=> alert_n);

  p_byte0_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == '0 |=> rd_data == $past(live_lo));

  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && rd_addr == '0) |=> $stable(snap));

  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> alert_n);

  p_oob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr >= AW'(NB) |=> rd_data == 8'h00);

  p_stay_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n && !rd_stb |=> !alert_n);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind irq_gather irq_gather_chk #(.NB(NB), .AW(AW), .PADW(PADW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_stb   (rd_stb_i),
  .rd_addr  (rd_addr_i),
  .rd_data  (rd_data_o),
  .alert_n  (alert_n_o),
  .edge_any (edge_any),
  .busy     (busy_q),
  .snap     (snap_q),
  .live_lo  (sync_q[7:0])
);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  fix;
  logic [23:0] usr;
  logic        rd;
  logic [2:0]  addr;
  logic [7:0]  rd_data;
  logic        alert_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string tag = "R9";

  always #4 clk = ~clk;

  irq_gather u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fix_req_i (fix),
    .usr_req_i (usr),
    .rd_stb_i  (rd),
    .rd_addr_i (addr),
    .rd_data_o (rd_data),
    .alert_n_o (alert_n)
  );

  // behavioural reference: delay line for synchronisation, flags for alert
  logic [31:0] hist [0:2];
  bit          m_pend, m_busy;
  logic [31:0] m_snap;
  logic [7:0]  m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) hist[i] = '0;
      m_pend = 0; m_busy = 0; m_snap = '0; m_data = '0;
    end else begin
      automatic bit          start = rd && addr == 3'd0;
      automatic bit          last  = rd && addr == 3'd3;
      automatic bit          rise  = |(hist[1] & ~hist[2]);
      automatic logic [31:0] view  = start ? hist[1] : m_snap;
      if (rd) m_data = (addr < 3'd4) ? 8'((view >> (int'(addr) * 8)) & 32'hFF) : 8'h00;
      if (start) m_snap = hist[1];
      if (start) m_busy = 1;
      else if (last) m_busy = 0;
      m_pend = rise || (m_pend && !start);
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = {usr, fix};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk({tag, " alert"}, 32'(alert_n), 32'(!(m_pend && !m_busy)));
      chk({tag, " data"},  32'(rd_data), 32'(m_data));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdb(logic [2:0] a);
    @(negedge clk);
    rd = 1'b1;
    addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; fix = '0; usr = '0; rd = 1'b0; addr = '0;
    step(4);
    rst_n = 1'b1;
    step(1);
    chk("R9 reset alert", 32'(alert_n), 32'd1);
    rdb(3'd1);
    chk("R9 reset snapshot", 32'(rd_data), 32'h00);

    tag = "R1";
    fix = 8'h08;
    step(2);
    chk("R1 latency not yet", 32'(alert_n), 32'd1);
    step(1);
    chk("R1 raised", 32'(alert_n), 32'd0);
    tag = "R8";
    step(5);
    chk("R8 held low", 32'(alert_n), 32'd0);

    tag = "R2";
    rdb(3'd0);
    chk("R2 released", 32'(alert_n), 32'd1);
    chk("R3 byte0", 32'(rd_data), 32'h08);
    rdb(3'd3);
    chk("R5 no pending after last", 32'(alert_n), 32'd1);
    chk("R10 last byte", 32'(rd_data), 32'h00);
    step(3);
    chk("R10 data held", 32'(rd_data), 32'h00);

    tag = "R6";
    usr = 24'h000001;
    step(4);
    chk("R1 user line raised", 32'(alert_n), 32'd0);
    rdb(3'd0);
    chk("R3 byte0 again", 32'(rd_data), 32'h08);
    rdb(3'd1);
    chk("R6 user bit0 in byte1", 32'(rd_data), 32'h01);
    tag = "R5";
    usr = 24'h000101;
    step(5);
    chk("R5 masked during readout", 32'(alert_n), 32'd1);
    rdb(3'd2);
    chk("R4 byte2 from snapshot", 32'(rd_data), 32'h00);
    rdb(3'd3);
    chk("R5 reasserted after last", 32'(alert_n), 32'd0);
    rdb(3'd0);
    rdb(3'd2);
    chk("R6 user bit8 in byte2", 32'(rd_data), 32'h01);
    rdb(3'd3);
    chk("R2 readout closed", 32'(alert_n), 32'd1);

    tag = "R7";
    step(6);
    chk("R7 steady high no alert", 32'(alert_n), 32'd1);
    fix = 8'h00; usr = 24'h0;
    step(6);
    chk("R7 falling no alert", 32'(alert_n), 32'd1);

    tag = "R6";
    rdb(3'd5);
    chk("R6 out of range", 32'(rd_data), 32'h00);
    fix = 8'h81;
    step(4);
    rdb(3'd0);
    chk("R3 capture multi bits", 32'(rd_data), 32'h81);
    rdb(3'd7);
    chk("R6 out of range 7", 32'(rd_data), 32'h00);
    rdb(3'd3);
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule